// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block is a one-dimensional linear cellular automaton register meant to feed pseudo-random stimulus into logic under built-in self-test. Every cell is one flip-flop. On an enabled clock edge each cell takes a new value from its two neighbours, and in some cells from itself as well. A rule vector, fixed when the block is built, gives each cell its own rule: rule 90 XORs the two neighbours, and rule 150 XORs the two neighbours with the cell's own value. Each cell therefore has at most one XOR stage in front of its flip-flop.

A build-time boundary mode sets what the two end cells see beyond the edge of the row. In null mode they see constant zero. In cyclic mode the ends wrap round to each other. The whole register is shown on a parallel output at all times.

A seed can be loaded before a run starts. The all-zero state never changes under these linear rules, so a zero seed, and the reset value as well, is replaced by a non-zero default. With a well chosen rule vector the register steps through every non-zero state before it repeats. One example is a 4-cell null-boundary row whose rules are 90, 150, 90, 150 counted from the left end.

Top module: `ca_pattern_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the register is set to the non-zero default seed. With the default parameters that value is 4'b0001, and `pattern` shows it after the edge.
- R2: When `load` is high and `seed` is non-zero, `pattern` equals `seed` after the edge. This holds whatever the value of `en`, because `load` has priority over stepping.
- R3: When `load` is high and `seed` is all zero, the register takes the non-zero default seed and not zero.
- R4: When `load` and `en` are both low, `pattern` keeps its value.
- R5: Bit i of `pattern` is cell i, and cell 0 is the left end. When `en` is high and `load` is low, a cell whose rule bit is 0 (rule 90) takes left XOR right. Both values are the ones before the edge.
- R6: A cell whose rule bit is 1 (rule 150) takes left XOR itself XOR right. All three values are the ones before the edge, so no cell sees a neighbour that was updated in the same edge.
- R7: In null boundary mode, the left neighbour of cell 0 and the right neighbour of the last cell are constant zero.
- R8: In cyclic boundary mode, the left neighbour of cell 0 is the last cell, and the right neighbour of the last cell is cell 0.
- R9: Take a 4-cell null-boundary row with rule bits 4'b1010 (rules 90, 150, 90, 150 from cell 0). Started from any non-zero seed, it passes through 15 distinct states and comes back to the seed on the 15th step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the automaton one step |
| load | input | 1 | Load `seed`; has priority over `en` |
| seed | input | CELLS | Seed value; zero is replaced by the default seed |
| pattern | output | CELLS | Registered automaton state, bit i is cell i |

## Verification
Reset, load and step each act on the edge at which they are sampled, and the result shows on `pattern` straight after that edge. There is one register stage and nothing behind it. The bench drives inputs on the falling edge and reads `pattern` at the next falling edge, so every check sees exactly one rising edge after its stimulus. Step checks compare against a model in the bench that works out each cell's rule from the state before the edge. The period check counts steps until the seed comes back.

// File: rtl/ca_pkg.sv
package ca_pkg;

  typedef enum logic {
    BND_NULL   = 1'b0,
    BND_CYCLIC = 1'b1
  } ca_boundary_e;

endpackage

// File: rtl/ca_seed_guard.sv
module ca_seed_guard #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] FALLBACK = 1
) (
  input  logic [WIDTH-1:0] seed_in,
  output logic [WIDTH-1:0] seed_out
);

  // The all-zero state is a fixed point of every linear rule mix.
  assign seed_out = (|seed_in) ? seed_in : FALLBACK;

endmodule

// File: rtl/ca_neighbour_map.sv
module ca_neighbour_map
  import ca_pkg::*;
#(
  parameter int           CELLS    = 4,
  parameter ca_boundary_e BOUNDARY = BND_NULL
) (
  input  logic [CELLS-1:0] state,
  output logic [CELLS-1:0] left_nb,
  output logic [CELLS-1:0] right_nb
);

  localparam int LAST = CELLS - 1;

  for (genvar i = 0; i < CELLS; i++) begin : g_map
    if (i == 0) begin : g_left_edge
      if (BOUNDARY == BND_CYCLIC) begin : g_wrap
        assign left_nb[i] = state[LAST];
      end else begin : g_zero
        assign left_nb[i] = 1'b0;
      end
    end else begin : g_left_in
      assign left_nb[i] = state[i-1];
    end

    if (i == LAST) begin : g_right_edge
      if (BOUNDARY == BND_CYCLIC) begin : g_wrap
        assign right_nb[i] = state[0];
      end else begin : g_zero
        assign right_nb[i] = 1'b0;
      end
    end else begin : g_right_in
      assign right_nb[i] = state[i+1];
    end
  end

endmodule

// File: rtl/ca_cell.sv
module ca_cell #(
  parameter bit RULE150   = 1'b0,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic load,
  input  logic load_val,
  input  logic left,
  input  logic right,
  output logic q
);

  logic nxt;

  if (RULE150) begin : g_r150
    assign nxt = left ^ q ^ right;
  end else begin : g_r90
    assign nxt = left ^ right;
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_VAL;
    else if (load) q <= load_val;
    else if (step) q <= nxt;
  end

  if (RULE150) begin : g_chk150
    p_rule150_step_r6: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (q == ($past(left) ^ $past(q) ^ $past(right))));
  end else begin : g_chk90
    p_rule90_step_r5: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (q == ($past(left) ^ $past(right))));
  end

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen
  import ca_pkg::*;
#(
  parameter int               CELLS        = 4,
  parameter logic [CELLS-1:0] RULES        = 4'b1010,
  parameter logic [CELLS-1:0] DEFAULT_SEED = 1,
  parameter ca_boundary_e     BOUNDARY     = BND_NULL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [CELLS-1:0] seed,
  output logic [CELLS-1:0] pattern
);

  localparam logic [CELLS-1:0] SAFE_SEED =
    (DEFAULT_SEED == '0) ? CELLS'(1) : DEFAULT_SEED;

  logic [CELLS-1:0] state;
  logic [CELLS-1:0] left_nb;
  logic [CELLS-1:0] right_nb;
  logic [CELLS-1:0] seed_ok;
  logic             step;

  assign step = en & ~load;

  ca_seed_guard #(
    .WIDTH   (CELLS),
    .FALLBACK(SAFE_SEED)
  ) u_guard (
    .seed_in (seed),
    .seed_out(seed_ok)
  );

  ca_neighbour_map #(
    .CELLS   (CELLS),
    .BOUNDARY(BOUNDARY)
  ) u_map (
    .state   (state),
    .left_nb (left_nb),
    .right_nb(right_nb)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    ca_cell #(
      .RULE150  (RULES[i]),
      .RESET_VAL(SAFE_SEED[i])
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .load    (load),
      .load_val(seed_ok[i]),
      .left    (left_nb[i]),
      .right   (right_nb[i]),
      .q       (state[i])
    );
  end

  assign pattern = state;

  p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
    (load && (seed != '0)) |=> (pattern == $past(seed)));

  p_zero_seed_r3: assert property (@(posedge clk) disable iff (rst)
    (load && (seed == '0)) |=> (pattern == SAFE_SEED));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(pattern));

endmodule

// File: tb/test_ca_pattern_gen.sv
module test_ca_pattern_gen;
  import ca_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a = 1'b0, load_a = 1'b0;
  logic [3:0] seed_a = '0;
  logic [3:0] pat_a;
  logic en_b = 1'b0, load_b = 1'b0;
  logic [4:0] seed_b = '0;
  logic [4:0] pat_b;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ca_pattern_gen #(
    .CELLS(4), .RULES(4'b1010), .DEFAULT_SEED(4'b0001), .BOUNDARY(BND_NULL)
  ) i_ca_pattern_gen (
    .clk(clk), .rst(rst), .en(en_a), .load(load_a), .seed(seed_a), .pattern(pat_a)
  );

  ca_pattern_gen #(
    .CELLS(5), .RULES(5'b00101), .DEFAULT_SEED(5'b10000), .BOUNDARY(BND_CYCLIC)
  ) i_ca_pattern_gen_cyc (
    .clk(clk), .rst(rst), .en(en_b), .load(load_b), .seed(seed_b), .pattern(pat_b)
  );

  // Independent model: n cells, rule bit 1 = rule 150, cell 0 is bit 0.
  function automatic logic [7:0] model_next(input logic [7:0] s, input int n,
                                            input logic [7:0] rules, input bit cyc);
    logic [7:0] r;
    logic l, rt;
    r = '0;
    for (int i = 0; i < n; i++) begin
      l  = (i == 0)     ? (cyc ? s[n-1] : 1'b0) : s[i-1];
      rt = (i == n - 1) ? (cyc ? s[0]   : 1'b0) : s[i+1];
      r[i] = l ^ rt ^ (rules[i] & s[i]);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check("R1 null reset seed", {4'b0, pat_a}, 8'b0000_0001);
    check("R1 cyclic reset seed", {3'b0, pat_b}, 8'b0001_0000);
    rst = 1'b0;
  endtask

  task automatic t_load();
    seed_a = 4'b1011; load_a = 1'b1; en_a = 1'b1;
    tick();
    check("R2 load beats enable", {4'b0, pat_a}, 8'h0B);
    seed_a = 4'b0110; tick();
    check("R2 second load", {4'b0, pat_a}, 8'h06);
    load_a = 1'b0; en_a = 1'b0;
  endtask

  task automatic t_zero_seed();
    seed_a = 4'b0000; load_a = 1'b1;
    tick();
    check("R3 zero seed replaced", {4'b0, pat_a}, 8'h01);
    seed_b = 5'b00000; load_b = 1'b1;
    tick();
    check("R3 zero seed replaced cyclic", {3'b0, pat_b}, 8'h10);
    load_a = 1'b0; load_b = 1'b0;
  endtask

  task automatic t_hold();
    seed_a = 4'b1001; load_a = 1'b1; tick(); load_a = 1'b0;
    en_a = 1'b0; seed_a = 4'b0110;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R4 hold with enable low", {4'b0, pat_a}, 8'h09);
    end
  endtask

  task automatic t_null_step();
    seed_a = 4'b0001; load_a = 1'b1; tick(); load_a = 1'b0;
    en_a = 1'b1; tick(); en_a = 1'b0;
    check("R7 null edge single step", {4'b0, pat_a}, 8'b0000_0010);
    seed_a = 4'b1000; load_a = 1'b1; tick(); load_a = 1'b0;
    en_a = 1'b1; tick(); en_a = 1'b0;
    // cell3 r150: c2^c3^0=1, cell2 r90: c1^c3=1 -> 1100
    check("R7 R6 null right edge step", {4'b0, pat_a}, 8'b0000_1100);
    seed_a = 4'b0100; load_a = 1'b1; tick(); load_a = 1'b0;
    en_a = 1'b1; tick(); en_a = 1'b0;
    // c1 r150 sees c2 -> 1, c2 r90: 0, c3 r150: c2 -> 1 -> 1010
    check("R5 R6 inner cell step", {4'b0, pat_a}, 8'b0000_1010);
  endtask

  task automatic t_cyclic();
    logic [7:0] exp;
    seed_b = 5'b00001; load_b = 1'b1; tick(); load_b = 1'b0;
    en_b = 1'b1; tick();
    check("R8 cyclic wrap step", {3'b0, pat_b}, 8'b0001_0011);
    exp = {3'b0, pat_b};
    for (int k = 0; k < 6; k++) begin
      exp = model_next(exp, 5, 8'b0000_0101, 1'b1);
      tick();
      check("R8 R5 R6 cyclic model step", {3'b0, pat_b}, exp);
    end
    en_b = 1'b0;
  endtask

  task automatic t_period();
    logic [15:0] seen;
    logic [7:0]  exp;
    int          steps;
    bit          back;
    seed_a = 4'b0111; load_a = 1'b1; tick(); load_a = 1'b0;
    seen = '0; seen[pat_a] = 1'b1; exp = {4'b0, pat_a};
    steps = 0; back = 1'b0;
    en_a = 1'b1;
    while (!back && steps < 20) begin
      tick();
      steps++;
      exp = model_next(exp, 4, 8'b0000_1010, 1'b0);
      if (steps <= 3) check("R5 R6 R7 null model step", {4'b0, pat_a}, exp);
      if (pat_a == 4'b0111) back = 1'b1;
      else seen[pat_a] = 1'b1;
    end
    en_a = 1'b0;
    check("R9 period length", 8'(steps), 8'd15);
    check("R9 distinct states", 8'($countones(seen)), 8'd15);
    check("R9 zero never visited", {7'b0, seen[0]}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_load();
    t_zero_seed();
    t_hold();
    t_null_step();
    t_cyclic();
    t_period();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule